// File: doc/BRIEF.md
# Weight-Stationary Systolic MAC Array

A two-dimensional grid of processing elements for neural-network inference. Every element keeps its own signed 8-bit weights in place, one for each of several parallel multiply-accumulate lanes. Signed 8-bit activations enter at the left edge and travel to the right one element per clock. Partial sums travel down each column. At the bottom edge, each column and lane feeds a 32-bit accumulator that saturates instead of wrapping.

Before computing, the weights are loaded through a column-wide port. They shift one column to the right on each load cycle. Activation beats are then presented one vector per cycle with a valid flag. The block adds the per-row delay itself. Results appear per column, with column c lagging column c-1 by one clock, and each update is flagged by that column's valid bit. Inside each element, a lane with a zero weight or a zero activation is held idle. Its lane-enable output, which stands in for a clock gate, stays low, and the lane adds nothing to the sum. A clear input zeroes every accumulator in one clock.

Top module: `ws_mac_array`

## Requirements
- R1: While `wLoad` is high, the weight registers shift one column per clock: column 0 takes `wCol` and column c takes the old value of column c-1. After COLS load cycles, the first vector presented sits in column COLS-1. While `wLoad` is low, the weights are held.
- R2: Weights and activations are two's-complement 8-bit values. Row r, lane l uses bits [(r*LANES+l)*8 +: 8] of `wCol` and `actIn`. One beat adds the sum over r of w[r][c][l]*a[r][l] to the accumulator of column c, lane l.
- R3: Each accumulator adds the results of successive beats. It holds its value on every clock in which its column receives no update.
- R4: An accumulation beyond +2147483647 or below -2147483648 leaves the accumulator at that limit. A later update of the opposite sign moves it away from the limit.
- R5: A beat sampled at clock edge E updates column c at edge E+ROWS+c+1. `resValid[c]` is high for exactly the one cycle after that edge.
- R6: `clrAcc` zeroes every accumulator and drops every `resValid` bit at the next edge. It takes priority over an update that lands on the same edge.
- R7: An activation beat presented while `wLoad` is high is ignored. It produces no lane activity and no result.
- R8: `laneEn` bit (r*COLS+c)*LANES+l is high only while a valid beat is at element (r,c) with a nonzero activation and a nonzero weight in lane l. A lane with a zero operand stays low.
- R9: After reset, all accumulators, weights, `resValid` and `laneEn` are zero.
- R10: Beats may be presented on every clock. Each one produces exactly one update per column.
- Result layout: column c, lane l occupies bits [(c*LANES+l)*32 +: 32] of `resData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wLoad | input | 1 | Shift the weight column registers by one column |
| wCol | input | ROWS*LANES*8 | Weight vector entering column 0 |
| actValid | input | 1 | Activation beat present |
| actIn | input | ROWS*LANES*8 | Activation beat, one byte per row and lane |
| clrAcc | input | 1 | Zero all accumulators |
| resValid | output | COLS | Per-column update flag |
| resData | output | COLS*LANES*32 | Saturating accumulators |
| laneEn | output | ROWS*COLS*LANES | Per-lane activity enable (gating stand-in) |

## Verification
A clear can arrive on the same edge as a column's accumulator update. The bench provokes this by sending one beat into non-zero accumulators and raising `clrAcc` exactly on the edge where column 2 receives that beat. The clear must win. Columns 0 to 2 must read zero with no valid pulse on column 2. Column 3, which updates one clock later, must hold only the fresh beat's sum and no older content.

// File: rtl/ws_mac_pkg.sv
`timescale 1ns/1ps
package ws_mac_pkg;
  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic wShift;  // shift weight columns
    logic actGo;   // accept an activation beat
    logic clrAcc;  // zero the accumulators
  } ctrl_t;
endpackage

// File: rtl/ws_mac_ctrl.sv
`timescale 1ns/1ps
module ws_mac_ctrl
  import ws_mac_pkg::*;
(
  input  logic  wLoad,
  input  logic  actValid,
  input  logic  clrAcc,
  output ctrl_t strobe
);
  // Loading has precedence: a beat offered during a load is dropped.
  always_comb begin
    strobe.wShift = wLoad;
    strobe.actGo  = actValid & ~wLoad;
    strobe.clrAcc = clrAcc;
  end
endmodule

// File: rtl/ws_mac_pe.sv
`timescale 1ns/1ps
module ws_mac_pe #(
  parameter int LANES = 2,
  parameter int DW    = 8,
  parameter int AW    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES*DW-1:0] act,
  input  logic [LANES*DW-1:0] wgt,
  input  logic               actVld,
  input  logic [LANES*AW-1:0] psumIn,
  output logic [LANES*AW-1:0] psumOut,
  output logic [LANES-1:0]   laneEn
);
  localparam int PW = 2 * DW;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic signed [DW-1:0] aV, wV;
    logic signed [PW-1:0] prodQ;
    logic                 enQ;
    logic [AW-1:0]        psumQ;
    logic [AW-1:0]        prodExt;

    assign aV = act[l*DW +: DW];
    assign wV = wgt[l*DW +: DW];
    // Sparsity detect: nothing useful to do when an operand is zero.
    assign laneEn[l] = actVld && (aV != '0) && (wV != '0);

    // Stage 1: product register, only clocked when the lane is active.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prodQ <= '0;
        enQ   <= 1'b0;
      end else begin
        enQ <= laneEn[l];
        if (laneEn[l]) prodQ <= aV * wV;
      end
    end

    assign prodExt = {{(AW-PW){prodQ[PW-1]}}, prodQ};

    // Stage 2: add to the partial sum arriving from the row above.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) psumQ <= '0;
      else       psumQ <= psumIn[l*AW +: AW] + (enQ ? prodExt : '0);
    end

    assign psumOut[l*AW +: AW] = psumQ;
  end
endmodule

// File: rtl/ws_mac_grid.sv
`timescale 1ns/1ps
module ws_mac_grid
  import ws_mac_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int LANES = 2,
  parameter int DW    = 8,
  parameter int AW    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_t                      strobe,
  input  logic [ROWS*LANES*DW-1:0]   wCol,
  input  logic [ROWS*LANES*DW-1:0]   actIn,
  output logic [COLS-1:0]            resValid,
  output logic [COLS*LANES*AW-1:0]   resData,
  output logic [ROWS*COLS*LANES-1:0] laneEn
);
  localparam int VW = LANES * DW;
  localparam int SW = LANES * AW;
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  logic [VW-1:0] wNet   [ROWS][COLS];
  logic [VW-1:0] peAct  [ROWS][COLS];
  logic          peVld  [ROWS][COLS];
  logic [SW-1:0] sumNet [ROWS+1][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    // Weight column shift chain.
    for (genvar c = 0; c < COLS; c++) begin : gW
      logic [VW-1:0] wq;
      logic [VW-1:0] wSrc;
      if (c == 0) begin : gFirst
        assign wSrc = wCol[r*VW +: VW];
      end else begin : gNext
        assign wSrc = wNet[r][c-1];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             wq <= '0;
        else if (strobe.wShift) wq <= wSrc;
      end
      assign wNet[r][c] = wq;
    end

    // Row entry delay: row r waits r cycles.
    if (r == 0) begin : gNoSkew
      assign peAct[r][0] = actIn[r*VW +: VW];
      assign peVld[r][0] = strobe.actGo;
    end else begin : gSkew
      logic [VW-1:0] skA [r];
      logic          skV [r];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < r; i++) begin
            skA[i] <= '0;
            skV[i] <= 1'b0;
          end
        end else begin
          skA[0] <= actIn[r*VW +: VW];
          skV[0] <= strobe.actGo;
          for (int i = 1; i < r; i++) begin
            skA[i] <= skA[i-1];
            skV[i] <= skV[i-1];
          end
        end
      end
      assign peAct[r][0] = skA[r-1];
      assign peVld[r][0] = skV[r-1];
    end

    // Horizontal activation pipeline, one register per element.
    for (genvar c = 1; c < COLS; c++) begin : gH
      logic [VW-1:0] aq;
      logic          vq;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          aq <= '0;
          vq <= 1'b0;
        end else begin
          aq <= peAct[r][c-1];
          vq <= peVld[r][c-1];
        end
      end
      assign peAct[r][c] = aq;
      assign peVld[r][c] = vq;
    end

    for (genvar c = 0; c < COLS; c++) begin : gPe
      ws_mac_pe #(.LANES(LANES), .DW(DW), .AW(AW)) pe (
        .clk     (clk),
        .rstN    (rstN),
        .act     (peAct[r][c]),
        .wgt     (wNet[r][c]),
        .actVld  (peVld[r][c]),
        .psumIn  (sumNet[r][c]),
        .psumOut (sumNet[r+1][c]),
        .laneEn  (laneEn[(r*COLS+c)*LANES +: LANES])
      );
    end
  end

  // Column accumulators at the bottom edge.
  for (genvar c = 0; c < COLS; c++) begin : gCol
    logic v1, v2, rv;
    assign sumNet[0][c] = '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        v1 <= 1'b0;
        v2 <= 1'b0;
        rv <= 1'b0;
      end else begin
        v1 <= peVld[ROWS-1][c];
        v2 <= v1;
        rv <= strobe.clrAcc ? 1'b0 : v2;
      end
    end
    assign resValid[c] = rv;

    for (genvar l = 0; l < LANES; l++) begin : gAcc
      logic [AW-1:0] accQ, addV, satV;
      logic [AW:0]   sumX;
      assign addV = sumNet[ROWS][c][l*AW +: AW];
      always_comb begin
        sumX = {accQ[AW-1], accQ} + {addV[AW-1], addV};
        if (sumX[AW] != sumX[AW-1]) satV = sumX[AW] ? MINV : MAXV;
        else                        satV = sumX[AW-1:0];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              accQ <= '0;
        else if (strobe.clrAcc) accQ <= '0;
        else if (v2)            accQ <= satV;
      end
      assign resData[(c*LANES+l)*AW +: AW] = accQ;
    end
  end
endmodule

// File: rtl/ws_mac_array.sv
`timescale 1ns/1ps
module ws_mac_array
  import ws_mac_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int LANES = 2,
  parameter int DW    = 8,
  parameter int AW    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wLoad,
  input  logic [ROWS*LANES*DW-1:0]   wCol,
  input  logic                       actValid,
  input  logic [ROWS*LANES*DW-1:0]   actIn,
  input  logic                       clrAcc,
  output logic [COLS-1:0]            resValid,
  output logic [COLS*LANES*AW-1:0]   resData,
  output logic [ROWS*COLS*LANES-1:0] laneEn
);
  ctrl_t strobe;

  ws_mac_ctrl ctrl (
    .wLoad    (wLoad),
    .actValid (actValid),
    .clrAcc   (clrAcc),
    .strobe   (strobe)
  );

  ws_mac_grid #(
    .ROWS(ROWS), .COLS(COLS), .LANES(LANES), .DW(DW), .AW(AW)
  ) grid (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wCol     (wCol),
    .actIn    (actIn),
    .resValid (resValid),
    .resData  (resData),
    .laneEn   (laneEn)
  );
endmodule

// File: rtl/ws_mac_checker.sv
`timescale 1ns/1ps
module ws_mac_checker #(
  parameter int COLS  = 4,
  parameter int LANES = 2,
  parameter int DW    = 8,
  parameter int AW    = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wLoad,
  input logic                     actValid,
  input logic                     clrAcc,
  input logic [LANES*DW-1:0]      act0,
  input logic [LANES-1:0]         lane0,
  input logic [COLS-1:0]          resValid,
  input logic [COLS*LANES*AW-1:0] resData
);
  localparam logic signed [AW-1:0] HI = {2'b01, {(AW-2){1'b0}}};
  localparam logic signed [AW-1:0] LO = {2'b11, {(AW-2){1'b0}}};

  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clrAcc |=> (resData == '0 && resValid == '0));

  a_r3_hold_between_updates: assert property (@(posedge clk) disable iff (!rstN)
    !clrAcc |=> (resValid != '0 || $stable(resData)));

  a_r7_load_keeps_lanes_idle: assert property (@(posedge clk) disable iff (!rstN)
    wLoad |-> lane0 == '0);

  for (genvar l = 0; l < LANES; l++) begin : gLane0
    a_r8_zero_operand_idle: assert property (@(posedge clk) disable iff (!rstN)
      lane0[l] |-> (actValid && !wLoad && act0[l*DW +: DW] != '0));
  end

  for (genvar c = 0; c < COLS; c++) begin : gC
    for (genvar l = 0; l < LANES; l++) begin : gL
      logic signed [AW-1:0] v;
      assign v = resData[(c*LANES+l)*AW +: AW];
      a_r4_no_wrap_high: assert property (@(posedge clk) disable iff (!rstN)
        (v > HI && !clrAcc) |=> v > 0);
      a_r4_no_wrap_low: assert property (@(posedge clk) disable iff (!rstN)
        (v < LO && !clrAcc) |=> v < 0);
    end
  end
endmodule

bind ws_mac_array ws_mac_checker #(
  .COLS(COLS), .LANES(LANES), .DW(DW), .AW(AW)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .wLoad    (wLoad),
  .actValid (actValid),
  .clrAcc   (clrAcc),
  .act0     (actIn[LANES*DW-1:0]),
  .lane0    (laneEn[LANES-1:0]),
  .resValid (resValid),
  .resData  (resData)
);

// File: tb/ws_mac_array_test.sv
`timescale 1ns/1ps
module ws_mac_array_test;
  localparam int ROWS = 4, COLS = 4, LANES = 2, DW = 8, AW = 32;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic clk = 1'b0, rstN = 1'b0, wLoad = 1'b0, actValid = 1'b0, clrAcc = 1'b0;
  logic [ROWS*LANES*DW-1:0]   wCol = '0, actIn = '0;
  logic [COLS-1:0]            resValid;
  logic [COLS*LANES*AW-1:0]   resData;
  logic [ROWS*COLS*LANES-1:0] laneEn;

  always #5 clk = ~clk;

  ws_mac_array #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rstN(rstN), .wLoad(wLoad), .wCol(wCol), .actValid(actValid),
    .actIn(actIn), .clrAcc(clrAcc), .resValid(resValid), .resData(resData),
    .laneEn(laneEn)
  );

  int errs = 0, checks = 0, cyc = 0;
  bit done = 1'b0;
  int pulses [COLS];
  int firstAt [COLS];
  logic [ROWS*COLS*LANES-1:0] laneSeen;
  longint expAcc [COLS][LANES];
  int W [ROWS][COLS][LANES];
  int A [ROWS][LANES];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    #2;
    for (int c = 0; c < COLS; c++)
      if (resValid[c]) begin
        pulses[c]++;
        if (firstAt[c] < 0) firstAt[c] = cyc;
      end
    laneSeen |= laneEn;
  endtask

  task automatic clearMon();
    for (int c = 0; c < COLS; c++) begin
      pulses[c] = 0;
      firstAt[c] = -1;
    end
    laneSeen = '0;
  endtask

  function automatic longint sat(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic longint colSum(int c, int l);
    longint s = 0;
    for (int r = 0; r < ROWS; r++) s += longint'(W[r][c][l]) * longint'(A[r][l]);
    return s;
  endfunction

  function automatic longint resVal(int c, int l);
    return longint'($signed(resData[(c*LANES+l)*AW +: AW]));
  endfunction

  task automatic sendBeat();
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++) actIn[(r*LANES+l)*DW +: DW] = A[r][l][DW-1:0];
    actValid = 1'b1;
    for (int c = 0; c < COLS; c++)
      for (int l = 0; l < LANES; l++) expAcc[c][l] = sat(expAcc[c][l] + colSum(c, l));
    step();
  endtask

  task automatic drain();
    actValid = 1'b0;
    repeat (ROWS + COLS + 3) step();
  endtask

  task automatic clearAcc();
    clrAcc = 1'b1;
    step();
    clrAcc = 1'b0;
    for (int c = 0; c < COLS; c++)
      for (int l = 0; l < LANES; l++) expAcc[c][l] = 0;
  endtask

  task automatic loadW(bit withAct);
    for (int k = 0; k < COLS; k++) begin
      for (int r = 0; r < ROWS; r++)
        for (int l = 0; l < LANES; l++)
          wCol[(r*LANES+l)*DW +: DW] = W[r][COLS-1-k][l][DW-1:0];
      wLoad = 1'b1;
      if (withAct) begin
        actValid = 1'b1;
        actIn = {(ROWS*LANES){8'h11}};
      end
      step();
    end
    wLoad = 1'b0;
    actValid = 1'b0;
  endtask

  task automatic checkAcc(string req, string what);
    for (int c = 0; c < COLS; c++)
      for (int l = 0; l < LANES; l++)
        check(resVal(c, l) == expAcc[c][l], req, $sformatf("%s col%0d lane%0d", what, c, l),
              resVal(c, l), expAcc[c][l]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    longint expLane;
    int e;
    clearMon();
    for (int c = 0; c < COLS; c++)
      for (int l = 0; l < LANES; l++) expAcc[c][l] = 0;

    // R9: reset state
    repeat (3) step();
    check(resData == '0, "R9", "resData in reset", longint'(resData[31:0]), 0);
    check(resValid == '0, "R9", "resValid in reset", longint'(resValid), 0);
    check(laneEn == '0, "R9", "laneEn in reset", longint'(laneEn), 0);
    rstN = 1'b1;
    step();

    // Weight set with some zero entries
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int l = 0; l < LANES; l++) begin
          W[r][c][l] = ((r*53 + c*29 + l*71 + 11) % 256) - 128;
          if ((r + 2*c + l) % 5 == 0) W[r][c][l] = 0;
        end

    // R7: beats offered during the load are dropped
    clearMon();
    loadW(1'b1);
    drain();
    for (int c = 0; c < COLS; c++)
      check(pulses[c] == 0, "R7", $sformatf("pulses col%0d during load", c), pulses[c], 0);
    check(laneSeen == '0, "R7", "lane activity during load", longint'(laneSeen), 0);
    checkAcc("R7", "acc after load");

    // R1: probe each row with a unit activation to read back placement
    for (int r = 0; r < ROWS; r++) begin
      for (int rr = 0; rr < ROWS; rr++)
        for (int l = 0; l < LANES; l++) A[rr][l] = (rr == r) ? 1 : 0;
      clearAcc();
      sendBeat();
      drain();
      for (int c = 0; c < COLS; c++)
        for (int l = 0; l < LANES; l++)
          check(resVal(c, l) == W[r][c][l], "R1",
                $sformatf("weight r%0d c%0d l%0d", r, c, l), resVal(c, l), W[r][c][l]);
    end

    // R5, R8, R2: single beat with zero activations
    clearAcc();
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++)
        A[r][l] = ((r + l) % 3 == 0) ? 0 : (r*40 - l*70 + 5);
    clearMon();
    e = cyc + 1;
    sendBeat();
    drain();
    for (int c = 0; c < COLS; c++) begin
      check(firstAt[c] == e + ROWS + c + 1, "R5", $sformatf("latency col%0d", c),
            firstAt[c], e + ROWS + c + 1);
      check(pulses[c] == 1, "R5", $sformatf("pulse count col%0d", c), pulses[c], 1);
    end
    checkAcc("R2", "single beat");
    expLane = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int l = 0; l < LANES; l++)
          if (A[r][l] != 0 && W[r][c][l] != 0) expLane |= (64'd1 << ((r*COLS+c)*LANES+l));
    check(longint'(laneSeen) == expLane, "R8", "lanes active", longint'(laneSeen), expLane);

    // R10, R3: back-to-back sweep over every activation value
    clearMon();
    for (int i = 0; i < 256; i++) begin
      for (int r = 0; r < ROWS; r++)
        for (int l = 0; l < LANES; l++) A[r][l] = ((i + r*17 + l*3) % 256) - 128;
      sendBeat();
    end
    drain();
    for (int c = 0; c < COLS; c++)
      check(pulses[c] == 256, "R10", $sformatf("updates col%0d", c), pulses[c], 256);
    checkAcc("R3", "after sweep");

    // R6: clear on the same edge as column 2's update
    clearAcc();
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++) A[r][l] = 9 - r*5 + l;
    sendBeat();
    drain();
    clearMon();
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++) A[r][l] = 30 + r*7 - l*50;
    e = cyc + 1;
    sendBeat();
    actValid = 1'b0;
    while (cyc < e + ROWS + 2) step();
    clrAcc = 1'b1;
    step();
    clrAcc = 1'b0;
    check(resValid == '0, "R6", "valid after clear", longint'(resValid), 0);
    for (int c = 0; c < 3; c++)
      for (int l = 0; l < LANES; l++)
        check(resVal(c, l) == 0, "R6", $sformatf("col%0d lane%0d after clear", c, l),
              resVal(c, l), 0);
    drain();
    for (int c = 0; c < COLS; c++)
      for (int l = 0; l < LANES; l++) expAcc[c][l] = (c == 3) ? colSum(3, l) : 0;
    checkAcc("R6", "after collision");
    check(pulses[2] == 0, "R6", "col2 pulse suppressed", pulses[2], 0);
    check(pulses[3] == 1, "R6", "col3 pulse", pulses[3], 1);

    // R4: saturation both ways
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int l = 0; l < LANES; l++) W[r][c][l] = -128;
    loadW(1'b0);
    clearAcc();
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++) A[r][l] = -128;
    repeat (32800) sendBeat();
    drain();
    checkAcc("R4", "positive limit");
    check(resVal(0, 0) == SMAX, "R4", "clamped high", resVal(0, 0), SMAX);
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < LANES; l++) A[r][l] = 127;
    sendBeat();
    drain();
    checkAcc("R4", "leave high limit");
    clearAcc();
    repeat (33100) sendBeat();
    drain();
    checkAcc("R4", "negative limit");
    check(resVal(COLS-1, LANES-1) == SMIN, "R4", "clamped low", resVal(COLS-1, LANES-1), SMIN);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule